// File: doc/BRIEF.md
# Floppy Drive Control Glue

This block sits between an 8-bit CPU bus and a floppy disk controller chip. It holds a small drive control register whose bits drive the four drive selects, the spindle motor, the head side and the density select of a 34-pin drive cable. The head side can either be taken from the controller's own side output or forced from the register. The density bit also drives the reduced-write-current line, so every high-density disk is written with reduced current.

The block also picks the clock fed to the controller. High-density media get the full CPU E rate, low-density media at 360 RPM get a tenth of a 12 MHz reference, and low-density media at 300 RPM get half the E rate. It decodes the chip select of the controller, forms read and write strobes from R/W and E, drives the data transceiver direction and enable from ungated signals, and turns the controller's data request into a fast interrupt request. All state is in the system clock domain; E and the reference are sampled and edge-detected.

Top module: `diskglue_top`

## Requirements
- R1: The controller chip select `fdc_cs_n_o` is low exactly for addresses $E018-$E01B; the control window is $E014-$E017, where address bit 0 = 0 selects the control register and bit 0 = 1 the speed register.
- R2: A bus write (`rw_i` = 0) inside the control window is taken when E falls; control register bits 3..0 drive `ds_o[3:0]`, bit 4 `motor_o`, bit 6 is the side source and bit 7 the density. After reset all bits are 0.
- R3: With side source 0, `side_o` follows `fdc_side_i`; with side source 1, `side_o` equals control bit 5 and `fdc_side_i` has no effect.
- R4: `hd_o` and `rwc_o` both equal the density bit.
- R5: Reading the control register returns {`hd_o`, side source, `side_o`, `motor_o`, `ds_o[3:0]`} from MSB to LSB; reading the speed register returns its bit 0 (1 = 360 RPM) with bits 7..1 zero. `data_oe_o` is high only while `rw_i` = 1, E = 1 and the address is in the control window.
- R6: `fdc_clk_o` runs at the E rate when density = 1, at the reference rate divided by 10 when density = 0 and the 360 RPM bit is 1, and at half the E rate otherwise (the reset state).
- R7: `rd_n_o` is low exactly while `rw_i` = 1 and E = 1, `wr_n_o` exactly while `rw_i` = 0 and E = 1; `xcvr_dir_o` equals `rw_i` and `xcvr_en_n_o` equals `fdc_cs_n_o`, both independent of E.
- R8: `firq_n_o` is low exactly while `fdc_drq_i` is high.
- R9: Writes outside the control window, and reads anywhere, leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | CPU address |
| rw_i | input | 1 | CPU read (1) / write (0) |
| e_i | input | 1 | CPU E clock |
| data_i | input | 8 | CPU write data |
| data_o | output | 8 | Register read-back data |
| data_oe_o | output | 1 | Read-back drive enable |
| ref12_i | input | 1 | 12 MHz reference clock |
| fdc_side_i | input | 1 | Side output of the controller chip |
| fdc_drq_i | input | 1 | Data request of the controller chip |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| fdc_cs_n_o | output | 1 | Controller chip select, active low |
| xcvr_dir_o | output | 1 | Data transceiver direction (1 = toward CPU) |
| xcvr_en_n_o | output | 1 | Data transceiver enable, active low |
| firq_n_o | output | 1 | Fast interrupt request, active low |
| ds_o | output | 4 | Drive selects 3..0 |
| motor_o | output | 1 | Motor on |
| side_o | output | 1 | Head side select |
| hd_o | output | 1 | High-density select |
| rwc_o | output | 1 | Reduced write current |
| fdc_clk_o | output | 1 | Clock to the controller chip |

## Verification
The hardest state to reach is a read-back that differs from what was written: the side bit only reads the controller's side line when the side source is 0, so the bench toggles `fdc_side_i` between accesses and reads the control register under both sources. The clock choice is observed only as a rate, so each of the three modes is set through register writes and the bench counts `fdc_clk_o` rising edges over a fixed window after a settling delay.

// File: rtl/diskglue_pkg.sv
package diskglue_pkg;

   typedef enum logic [1:0] {
      CSRC_E_HALF = 2'd0,
      CSRC_REF    = 2'd1,
      CSRC_E_FULL = 2'd2
   } clk_src_e;

   typedef struct packed {
      logic       density;
      logic       side_from_reg;
      logic       side;
      logic       motor;
      logic [3:0] drive;
   } ctl_reg_t;

endpackage

// File: rtl/diskglue_decode.sv
module diskglue_decode #(
   parameter int          AW       = 16,
   parameter int          WIN_BITS = 2,
   parameter logic [15:0] CTL_BASE = 16'hE014,
   parameter logic [15:0] FDC_BASE = 16'hE018
) (
   input  logic [AW-1:0] addr_i,
   input  logic          rw_i,
   input  logic          e_i,
   output logic          ctl_hit_o,
   output logic          ctl_sub_o,
   output logic          fdc_cs_n_o,
   output logic          rd_n_o,
   output logic          wr_n_o,
   output logic          xcvr_dir_o,
   output logic          xcvr_en_n_o
);
   localparam int TOP = AW - 1;

   if (WIN_BITS < 1 || WIN_BITS >= AW)
      $error("diskglue_decode: WIN_BITS out of range");
   if (CTL_BASE[WIN_BITS-1:0] != '0 || FDC_BASE[WIN_BITS-1:0] != '0)
      $error("diskglue_decode: base not aligned to window");
   if (CTL_BASE[TOP:WIN_BITS] == FDC_BASE[TOP:WIN_BITS])
      $error("diskglue_decode: windows overlap");

   logic fdc_hit;

   always_comb begin
      ctl_hit_o   = (addr_i[TOP:WIN_BITS] == CTL_BASE[TOP:WIN_BITS]);
      fdc_hit     = (addr_i[TOP:WIN_BITS] == FDC_BASE[TOP:WIN_BITS]);
      ctl_sub_o   = addr_i[0];
      fdc_cs_n_o  = ~fdc_hit;
      rd_n_o      = ~(rw_i & e_i);
      wr_n_o      = ~(~rw_i & e_i);
      xcvr_dir_o  = rw_i;
      xcvr_en_n_o = ~fdc_hit;
   end

   // R1: the two windows never select together
   always_comb begin
      a_r1_windows_exclusive: assert (!(ctl_hit_o && !fdc_cs_n_o));
   end
endmodule

// File: rtl/diskglue_clksel.sv
module diskglue_clksel
   import diskglue_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REF_DIV     = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic e_i,
   input  logic ref_i,
   input  logic sel_hd_i,
   input  logic sel_360_i,
   output logic e_fall_o,
   output logic fdc_clk_o
);
   localparam int HALF = REF_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (REF_DIV < 2 || (REF_DIV % 2) != 0)
      $error("diskglue_clksel: REF_DIV must be even and at least 2");
   if (SYNC_STAGES < 1)
      $error("diskglue_clksel: SYNC_STAGES must be at least 1");

   logic [SYNC_STAGES:0] e_sh, r_sh;

   always_comb begin
      e_sh[0] = e_i;
      r_sh[0] = ref_i;
   end

   for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_sh[i] <= 1'b0;
            r_sh[i] <= 1'b0;
         end else begin
            e_sh[i] <= e_sh[i-1];
            r_sh[i] <= r_sh[i-1];
         end
      end
   end

   logic e_prev, r_prev, e_rise, r_rise;
   logic e_lvl, r_lvl;

   always_comb begin
      e_lvl    = e_sh[SYNC_STAGES];
      r_lvl    = r_sh[SYNC_STAGES];
      e_rise   = e_lvl & ~e_prev;
      e_fall_o = ~e_lvl & e_prev;
      r_rise   = r_lvl & ~r_prev;
   end

   logic          div_e, div_r;
   logic [CW-1:0] r_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_prev <= 1'b0;
         r_prev <= 1'b0;
         div_e  <= 1'b0;
         div_r  <= 1'b0;
         r_cnt  <= '0;
      end else begin
         e_prev <= e_lvl;
         r_prev <= r_lvl;
         if (e_rise)
            div_e <= ~div_e;
         if (r_rise) begin
            if (r_cnt == CW'(HALF - 1)) begin
               r_cnt <= '0;
               div_r <= ~div_r;
            end else begin
               r_cnt <= r_cnt + 1'b1;
            end
         end
      end
   end

   clk_src_e src;

   always_comb begin
      if (sel_hd_i)
         src = CSRC_E_FULL;
      else if (sel_360_i)
         src = CSRC_REF;
      else
         src = CSRC_E_HALF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fdc_clk_o <= 1'b0;
      else begin
         case (src)
            CSRC_E_FULL: fdc_clk_o <= e_lvl;
            CSRC_REF:    fdc_clk_o <= div_r;
            default:     fdc_clk_o <= div_e;
         endcase
      end
   end

   // R6: the half-rate divider moves only after an E rising edge
   a_r6_half_follows_e: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_e) |-> $past(e_rise));
   // R6: the reference divider moves only after a reference rising edge
   a_r6_ref_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_r) |-> $past(r_rise));
endmodule

// File: rtl/diskglue_ctlreg.sv
module diskglue_ctlreg
   import diskglue_pkg::*;
#(
   parameter int DW     = 8,
   parameter int DRIVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              sub_i,
   input  logic [DW-1:0]     data_i,
   input  logic              fdc_side_i,
   output logic [DRIVES-1:0] ds_o,
   output logic              motor_o,
   output logic              side_o,
   output logic              hd_o,
   output logic              rpm360_o,
   output logic [DW-1:0]     rdata_o
);
   if (DW != $bits(ctl_reg_t))
      $error("diskglue_ctlreg: DW must match the register layout");
   if (DRIVES < 1 || DRIVES > 4)
      $error("diskglue_ctlreg: DRIVES must be 1 to 4");

   ctl_reg_t ctl_q;
   logic     spd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         spd_q <= 1'b0;
      end else if (wr_i) begin
         if (sub_i)
            spd_q <= data_i[0];
         else
            ctl_q <= ctl_reg_t'(data_i);
      end
   end

   for (genvar d = 0; d < DRIVES; d++) begin : g_ds
      assign ds_o[d] = ctl_q.drive[d];
   end

   logic [3:0] ds_pins;
   for (genvar d = 0; d < 4; d++) begin : g_fb
      if (d < DRIVES) begin : g_live
         assign ds_pins[d] = ds_o[d];
      end else begin : g_none
         assign ds_pins[d] = 1'b0;
      end
   end

   always_comb begin
      motor_o  = ctl_q.motor;
      hd_o     = ctl_q.density;
      rpm360_o = spd_q;
      side_o   = ctl_q.side_from_reg ? ctl_q.side : fdc_side_i;
      if (sub_i)
         rdata_o = {{(DW-1){1'b0}}, spd_q};
      else
         rdata_o = {hd_o, ctl_q.side_from_reg, side_o, motor_o, ds_pins};
   end

   // R2/R9: register contents move only on an accepted write
   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(ctl_q) && $stable(spd_q)));
endmodule

// File: rtl/diskglue_top.sv
module diskglue_top
   import diskglue_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          DRIVES      = 4,
   parameter int          WIN_BITS    = 2,
   parameter logic [15:0] CTL_BASE    = 16'hE014,
   parameter logic [15:0] FDC_BASE    = 16'hE018,
   parameter int          SYNC_STAGES = 2,
   parameter int          REF_DIV     = 10,
   parameter bit          DRQ_LOW     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr_i,
   input  logic              rw_i,
   input  logic              e_i,
   input  logic [DW-1:0]     data_i,
   output logic [DW-1:0]     data_o,
   output logic              data_oe_o,
   input  logic              ref12_i,
   input  logic              fdc_side_i,
   input  logic              fdc_drq_i,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              fdc_cs_n_o,
   output logic              xcvr_dir_o,
   output logic              xcvr_en_n_o,
   output logic              firq_n_o,
   output logic [DRIVES-1:0] ds_o,
   output logic              motor_o,
   output logic              side_o,
   output logic              hd_o,
   output logic              rwc_o,
   output logic              fdc_clk_o
);
   logic ctl_hit, ctl_sub, e_fall, wr_ctl, rpm360;

   diskglue_decode #(
      .AW(AW), .WIN_BITS(WIN_BITS), .CTL_BASE(CTL_BASE), .FDC_BASE(FDC_BASE)
   ) u_dec (
      .addr_i(addr_i), .rw_i(rw_i), .e_i(e_i),
      .ctl_hit_o(ctl_hit), .ctl_sub_o(ctl_sub), .fdc_cs_n_o(fdc_cs_n_o),
      .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
      .xcvr_dir_o(xcvr_dir_o), .xcvr_en_n_o(xcvr_en_n_o)
   );

   diskglue_clksel #(
      .SYNC_STAGES(SYNC_STAGES), .REF_DIV(REF_DIV)
   ) u_clk (
      .clk(clk), .rst_n(rst_n), .e_i(e_i), .ref_i(ref12_i),
      .sel_hd_i(hd_o), .sel_360_i(rpm360),
      .e_fall_o(e_fall), .fdc_clk_o(fdc_clk_o)
   );

   always_comb wr_ctl = e_fall & ~rw_i & ctl_hit;

   diskglue_ctlreg #(
      .DW(DW), .DRIVES(DRIVES)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ctl), .sub_i(ctl_sub),
      .data_i(data_i), .fdc_side_i(fdc_side_i),
      .ds_o(ds_o), .motor_o(motor_o), .side_o(side_o), .hd_o(hd_o),
      .rpm360_o(rpm360), .rdata_o(data_o)
   );

   always_comb begin
      rwc_o     = hd_o;
      data_oe_o = rw_i & e_i & ctl_hit;
   end

   if (DRQ_LOW) begin : g_drq_low
      assign firq_n_o = fdc_drq_i;
   end else begin : g_drq_high
      assign firq_n_o = ~fdc_drq_i;
   end

   // R4: density changes only as the result of a control write
   a_r4_density_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hd_o) |-> $past(wr_ctl));
   // R5: read-back is never driven during a write cycle
   a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> !data_oe_o);
endmodule

// File: tb/diskglue_top_test.sv
module diskglue_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        rw = 1'b1;
   logic        e = 1'b0;
   logic [7:0]  din = 8'h00;
   logic        ref12 = 1'b0;
   logic        fside = 1'b0;
   logic        drq = 1'b0;
   logic [7:0]  dout;
   logic        doe, rd_n, wr_n, cs_n, xdir, xen_n, firq_n;
   logic [3:0]  ds;
   logic        motor, side, hd, rwc, fclk;

   int compared = 0;
   int mismatched = 0;
   bit chk_en = 1'b0;
   bit done = 1'b0;

   logic [7:0] m_ctl = 8'h00;
   logic       m_spd = 1'b0;

   diskglue_top uut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .rw_i(rw), .e_i(e),
      .data_i(din), .data_o(dout), .data_oe_o(doe), .ref12_i(ref12),
      .fdc_side_i(fside), .fdc_drq_i(drq), .rd_n_o(rd_n), .wr_n_o(wr_n),
      .fdc_cs_n_o(cs_n), .xcvr_dir_o(xdir), .xcvr_en_n_o(xen_n),
      .firq_n_o(firq_n), .ds_o(ds), .motor_o(motor), .side_o(side),
      .hd_o(hd), .rwc_o(rwc), .fdc_clk_o(fclk)
   );

   always #10 clk = ~clk;
   initial begin
      #245;
      forever #240 e = ~e;
   end
   initial begin
      #5;
      forever #40 ref12 = ~ref12;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic m_side();
      return m_ctl[6] ? m_ctl[5] : fside;
   endfunction

   // continuous reference comparison on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R7", "rd_n", rd_n, !(rw && e));
         check("R7", "wr_n", wr_n, !(!rw && e));
         check("R1", "fdc_cs_n", cs_n, !(addr >= 16'hE018 && addr <= 16'hE01B));
         check("R7", "xcvr_dir", xdir, rw);
         check("R7", "xcvr_en_n", xen_n, !(addr >= 16'hE018 && addr <= 16'hE01B));
         check("R8", "firq_n", firq_n, !drq);
         check("R5", "data_oe", doe, rw && e && addr >= 16'hE014 && addr <= 16'hE017);
         if (chk_en) begin
            check("R2", "ds", ds, m_ctl[3:0]);
            check("R2", "motor", motor, m_ctl[4]);
            check("R3", "side", side, m_side());
            check("R4", "hd", hd, m_ctl[7]);
            check("R4", "rwc", rwc, m_ctl[7]);
         end
      end
   end

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      chk_en = 1'b0;
      addr = a; rw = 1'b0; din = d;
      @(posedge e);
      @(negedge e);
      repeat (5) @(posedge clk);
      #2;
      if (a >= 16'hE014 && a <= 16'hE017) begin
         if (a[0]) m_spd = d[0];
         else      m_ctl = d;
      end
      addr = 16'h0000; rw = 1'b1; din = 8'h00;
      chk_en = 1'b1;
   endtask

   task automatic bus_read(input logic [15:0] a, input string req);
      @(posedge clk); #2;
      addr = a; rw = 1'b1;
      @(posedge e);
      repeat (2) @(negedge clk);
      if (a[0])
         check(req, "read speed", dout, {7'b0, m_spd});
      else
         check(req, "read control", dout, {m_ctl[7], m_ctl[6], m_side(), m_ctl[4], m_ctl[3:0]});
      @(negedge e);
      @(posedge clk); #2;
      addr = 16'h0000;
   endtask

   task automatic measure(input int exp, input string what);
      int cnt = 0;
      logic prev;
      repeat (200) @(negedge clk);
      prev = fclk;
      repeat (480) begin
         @(negedge clk);
         if (fclk && !prev) cnt++;
         prev = fclk;
      end
      compared++;
      if (cnt < exp - 1 || cnt > exp + 1) begin
         mismatched++;
         $display("FAIL R6 %s: actual %0d edges expected %0d", what, cnt, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // reset state: all outputs low, 1 MHz equivalent clock
      check("R2", "reset ds", ds, 0);
      check("R2", "reset motor", motor, 0);
      check("R4", "reset hd", hd, 0);
      chk_en = 1'b1;
      measure(10, "reset half-E rate");

      // drive selects and motor
      bus_write(16'hE014, 8'h11);
      bus_read(16'hE014, "R5");
      bus_write(16'hE014, 8'h1A);
      bus_read(16'hE016, "R5");

      // side from controller, then forced from register
      @(posedge clk); #2 fside = 1'b1;
      bus_read(16'hE014, "R3");
      @(posedge clk); #2 fside = 1'b0;
      bus_read(16'hE014, "R3");
      bus_write(16'hE014, 8'h64);
      @(posedge clk); #2 fside = 1'b0;
      bus_read(16'hE014, "R3");
      @(posedge clk); #2 fside = 1'b1;
      bus_read(16'hE014, "R3");
      bus_write(16'hE014, 8'h44);
      bus_read(16'hE014, "R3");

      // 360 RPM low density: reference / 10
      bus_write(16'hE015, 8'hFF);
      bus_read(16'hE015, "R5");
      measure(12, "360 RPM reference rate");

      // high density overrides speed: full E rate, reduced write current
      bus_write(16'hE014, 8'h91);
      bus_read(16'hE014, "R4");
      measure(20, "high density E rate");

      // back to 300 RPM low density
      bus_write(16'hE014, 8'h01);
      bus_write(16'hE015, 8'h00);
      bus_read(16'hE017, "R5");
      measure(10, "300 RPM half-E rate");

      // writes outside the control window leave registers unchanged
      bus_write(16'hE018, 8'hFF);
      bus_write(16'hE013, 8'hFF);
      bus_write(16'hE01B, 8'h80);
      bus_read(16'hE014, "R9");
      bus_read(16'hE015, "R9");

      // controller window selects the chip, DRQ reaches FIRQ
      bus_read(16'hE019, "R1");
      @(posedge clk); #2 addr = 16'hE01A; rw = 1'b0;
      repeat (4) @(posedge clk);
      #2 addr = 16'h0000; rw = 1'b1;
      @(posedge clk); #2 drq = 1'b1;
      repeat (3) @(posedge clk);
      #2 drq = 1'b0;
      repeat (3) @(posedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule